// File: doc/BRIEF.md
# Lazy Chunk Writeback Tracker

This block keeps the dirtiness record for a directly addressed local store, at the granularity of 64-byte chunks. Every store event carries the local chunk index and the identifier of the address-map entry that covers the data. The first store to a clean chunk marks it dirty, remembers which map entry wrote it, and raises that map entry's live count of dirty chunks. Later stores to a chunk that is already dirty change nothing.

Writebacks are deferred. No store and no synchronisation point produces one. A writeback happens only when storage is reclaimed through an eviction request. When the evicted chunk is dirty, the tracker presents a writeback request that carries the chunk index and the map entry recorded for that chunk, so that a downstream translator can form the global address. The chunk stays dirty until the consumer accepts the request. On acceptance the dirty bit clears and the map entry's count drops by one. When the evicted chunk is clean, no request is made.

Moving the data and translating addresses belong to other blocks.

Top module: `lazy_wb_tracker`

## Requirements
- R1: After reset every chunk is clean, every per-map dirty count is zero, `wb_valid` is low and `ev_ready` is high.
- R2: A store (`st_valid` high at a clock edge) to a clean chunk makes the chunk dirty and raises the count of map `st_map` by one after that edge. It also records `st_map` as the chunk's owner.
- R3: A store to a chunk that is already dirty leaves every count and the recorded owner unchanged. A later writeback of that chunk reports the owner from the first store.
- R4: An eviction accepted (`ev_valid` and `ev_ready` high at an edge) for a dirty chunk raises `wb_valid` after that edge. `wb_chunk` then equals the evicted index, `wb_map` equals the recorded owner, and `ev_ready` is low while the request is pending.
- R5: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_chunk` and `wb_map` hold their values.
- R6: The chunk's dirty bit stays set until the writeback is accepted (`wb_valid` and `wb_ready` high at an edge). After that edge the bit is clear, the owner's count is one lower, and `wb_valid` is low.
- R7: An accepted eviction of a clean chunk produces no writeback request and leaves every count and dirty bit unchanged.
- R8: Stores never produce writebacks. `wb_valid` rises only in the cycle after an accepted eviction.
- R9: At every cycle the per-map counts sum to the number of dirty chunks. No count is decremented from zero.
- R10: A store that dirties a clean chunk in the same cycle as a writeback acceptance for the same map leaves that map's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store event this cycle |
| st_chunk | input | IDX_W | Local chunk index of the store |
| st_map | input | MAP_W | Map-entry id of the store |
| ev_valid | input | 1 | Eviction request |
| ev_ready | output | 1 | Eviction can be taken (no writeback pending) |
| ev_chunk | input | IDX_W | Chunk index to evict |
| wb_valid | output | 1 | Writeback request pending |
| wb_ready | input | 1 | Consumer accepts the writeback |
| wb_chunk | output | IDX_W | Chunk index of the writeback |
| wb_map | output | MAP_W | Recorded map-entry id of the writeback |
| chunk_dirty | output | NUM_CHUNKS | Dirty bit per chunk, bit i for chunk i |
| dirty_cnt | output | NUM_MAPS*CNT_W | Dirty-chunk count per map, map i at bits [i*CNT_W +: CNT_W] |

## Verification
The assertions assume several things about the inputs. Chunk and map indices are in range. No store targets the chunk whose writeback is pending or being accepted. A store and an eviction in the same cycle never name the same chunk. The bench keeps within these limits. It runs each eviction through to acceptance before it issues the next store. The only deliberate overlap, the same-map count collision, uses a store to a different chunk from the one being written back. The sweeps cover every chunk of a small configuration under two map-assignment patterns, repeated stores, evictions of clean chunks, and several stall lengths on the writeback handshake.

// File: rtl/lcwt_pkg.sv
// Package: shared types for the lazy chunk writeback tracker.
// Assumes nothing; holds only the writeback issue state encoding.
package lcwt_pkg;

    typedef enum logic {
        WB_IDLE = 1'b0,
        WB_PEND = 1'b1
    } wb_state_e;

endpackage

// File: rtl/lcwt_chunk_state.sv
// Per-chunk dirty bit and owning map-entry id.
// Assumes set and clear never name the same chunk in one cycle.
module lcwt_chunk_state #(
    parameter int NUM_CHUNKS = 16,
    parameter int IDX_W      = 4,
    parameter int MAP_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic [MAP_W-1:0]      set_map,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_idx,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [MAP_W-1:0]      rd_map,
    output logic [NUM_CHUNKS-1:0] dirty
);

    logic [MAP_W-1:0] owner [NUM_CHUNKS];

    for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
        // Update one chunk's dirty bit and owner.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dirty[i] <= 1'b0;
                owner[i] <= '0;
            end else if (set_en && set_idx == IDX_W'(i)) begin
                dirty[i] <= 1'b1;
                owner[i] <= set_map;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
                dirty[i] <= 1'b0;
            end
        end
    end

    // Look up the recorded owner for the chunk being evicted.
    always_comb begin
        rd_map = owner[rd_idx];
    end

endmodule

// File: rtl/lcwt_map_counters.sv
// One live dirty-chunk counter per map entry.
// Assumes a decrement is requested only for a map whose count is nonzero.
module lcwt_map_counters #(
    parameter int NUM_MAPS = 4,
    parameter int MAP_W    = 2,
    parameter int CNT_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc_en,
    input  logic [MAP_W-1:0]          inc_map,
    input  logic                      dec_en,
    input  logic [MAP_W-1:0]          dec_map,
    output logic [NUM_MAPS*CNT_W-1:0] counts
);

    for (genvar i = 0; i < NUM_MAPS; i++) begin : g_map
        logic             up;
        logic             down;
        logic [CNT_W-1:0] cnt;

        // Decode whether this map gains or loses a dirty chunk.
        always_comb begin
            up   = inc_en && (inc_map == MAP_W'(i));
            down = dec_en && (dec_map == MAP_W'(i));
        end

        // Keep the count; a simultaneous gain and loss cancel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (up && !down) begin
                cnt <= cnt + CNT_W'(1);
            end else if (down && !up) begin
                cnt <= cnt - CNT_W'(1);
            end
        end

        assign counts[i*CNT_W +: CNT_W] = cnt;
    end

endmodule

// File: rtl/lcwt_wb_issue.sv
// Single-entry writeback request register with valid/ready output.
// Assumes the eviction's dirty flag and owner are sampled in the request cycle.
module lcwt_wb_issue #(
    parameter int IDX_W = 4,
    parameter int MAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    output logic             ev_ready,
    input  logic [IDX_W-1:0] ev_chunk,
    input  logic             ev_dirty,
    input  logic [MAP_W-1:0] ev_map,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [IDX_W-1:0] wb_chunk,
    output logic [MAP_W-1:0] wb_map,
    output logic             wb_fire
);

    import lcwt_pkg::*;

    wb_state_e        state;
    logic [IDX_W-1:0] chunk_q;
    logic [MAP_W-1:0] map_q;

    // Handshake decode for both sides.
    always_comb begin
        ev_ready = (state == WB_IDLE);
        wb_valid = (state == WB_PEND);
        wb_fire  = wb_valid && wb_ready;
        wb_chunk = chunk_q;
        wb_map   = map_q;
    end

    // Capture a dirty eviction and hold it until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= WB_IDLE;
            chunk_q <= '0;
            map_q   <= '0;
        end else begin
            case (state)
                WB_IDLE: begin
                    if (ev_valid && ev_dirty) begin
                        state   <= WB_PEND;
                        chunk_q <= ev_chunk;
                        map_q   <= ev_map;
                    end
                end
                WB_PEND: begin
                    if (wb_ready) begin
                        state <= WB_IDLE;
                    end
                end
                default: state <= WB_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lazy_wb_tracker.sv
// Top: tracks chunk dirtiness and owners and defers writeback until eviction.
// Assumes no store targets a chunk whose writeback is pending, and a store and
// an eviction never name the same chunk in one cycle.
module lazy_wb_tracker #(
    parameter int NUM_CHUNKS = 16,
    parameter int NUM_MAPS   = 4,
    parameter int IDX_W      = $clog2(NUM_CHUNKS),
    parameter int MAP_W      = $clog2(NUM_MAPS),
    parameter int CNT_W      = $clog2(NUM_CHUNKS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      st_valid,
    input  logic [IDX_W-1:0]          st_chunk,
    input  logic [MAP_W-1:0]          st_map,
    input  logic                      ev_valid,
    output logic                      ev_ready,
    input  logic [IDX_W-1:0]          ev_chunk,
    output logic                      wb_valid,
    input  logic                      wb_ready,
    output logic [IDX_W-1:0]          wb_chunk,
    output logic [MAP_W-1:0]          wb_map,
    output logic [NUM_CHUNKS-1:0]     chunk_dirty,
    output logic [NUM_MAPS*CNT_W-1:0] dirty_cnt
);

    logic             first_write;
    logic             wb_fire;
    logic [MAP_W-1:0] ev_owner;
    logic             ev_is_dirty;

    // A store counts only when it turns a clean chunk dirty.
    always_comb begin
        first_write = st_valid && !chunk_dirty[st_chunk];
        ev_is_dirty = chunk_dirty[ev_chunk];
    end

    lcwt_chunk_state #(
        .NUM_CHUNKS(NUM_CHUNKS),
        .IDX_W     (IDX_W),
        .MAP_W     (MAP_W)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (first_write),
        .set_idx(st_chunk),
        .set_map(st_map),
        .clr_en (wb_fire),
        .clr_idx(wb_chunk),
        .rd_idx (ev_chunk),
        .rd_map (ev_owner),
        .dirty  (chunk_dirty)
    );

    lcwt_map_counters #(
        .NUM_MAPS(NUM_MAPS),
        .MAP_W   (MAP_W),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_en (first_write),
        .inc_map(st_map),
        .dec_en (wb_fire),
        .dec_map(wb_map),
        .counts (dirty_cnt)
    );

    lcwt_wb_issue #(
        .IDX_W(IDX_W),
        .MAP_W(MAP_W)
    ) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_valid(ev_valid),
        .ev_ready(ev_ready),
        .ev_chunk(ev_chunk),
        .ev_dirty(ev_is_dirty),
        .ev_map  (ev_owner),
        .wb_valid(wb_valid),
        .wb_ready(wb_ready),
        .wb_chunk(wb_chunk),
        .wb_map  (wb_map),
        .wb_fire (wb_fire)
    );

endmodule

// Checker: temporal properties of the tracker's ports.
// Assumes the input constraints stated on the top module.
module lazy_wb_tracker_chk #(
    parameter int NUM_CHUNKS = 16,
    parameter int NUM_MAPS   = 4,
    parameter int IDX_W      = 4,
    parameter int MAP_W      = 2,
    parameter int CNT_W      = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      st_valid,
    input logic [IDX_W-1:0]          st_chunk,
    input logic                      ev_valid,
    input logic                      ev_ready,
    input logic [IDX_W-1:0]          ev_chunk,
    input logic                      wb_valid,
    input logic                      wb_ready,
    input logic [IDX_W-1:0]          wb_chunk,
    input logic [MAP_W-1:0]          wb_map,
    input logic [NUM_CHUNKS-1:0]     chunk_dirty,
    input logic [NUM_MAPS*CNT_W-1:0] dirty_cnt
);

    int cnt_sum;
    int owner_cnt;

    // Sum the per-map counts and pick the count of the writeback owner.
    always_comb begin
        cnt_sum = 0;
        for (int i = 0; i < NUM_MAPS; i++) begin
            cnt_sum = cnt_sum + int'(dirty_cnt[i*CNT_W +: CNT_W]);
        end
        owner_cnt = int'(dirty_cnt[int'(wb_map)*CNT_W +: CNT_W]);
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wb_valid && ev_ready && chunk_dirty == '0 && dirty_cnt == '0));

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !chunk_dirty[st_chunk]) |=> chunk_dirty[$past(st_chunk)]);

    p_redirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && chunk_dirty[st_chunk] && !(wb_valid && wb_ready)) |=> $stable(dirty_cnt));

    p_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && chunk_dirty[ev_chunk]) |=>
            (wb_valid && !ev_ready && wb_chunk == $past(ev_chunk)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_chunk) && $stable(wb_map)));

    p_keep_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> chunk_dirty[$past(wb_chunk)]);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready) |=> (!wb_valid && !chunk_dirty[$past(wb_chunk)]));

    p_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && !chunk_dirty[ev_chunk] && !st_valid) |=>
            (!wb_valid && $stable(dirty_cnt) && $stable(chunk_dirty)));

    p_lazy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> $past(ev_valid && ev_ready));

    p_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_sum == $countones(chunk_dirty));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready) |-> owner_cnt != 0);

endmodule

bind lazy_wb_tracker lazy_wb_tracker_chk #(
    .NUM_CHUNKS(NUM_CHUNKS),
    .NUM_MAPS  (NUM_MAPS),
    .IDX_W     (IDX_W),
    .MAP_W     (MAP_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_chunk   (st_chunk),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_chunk   (ev_chunk),
    .wb_valid   (wb_valid),
    .wb_ready   (wb_ready),
    .wb_chunk   (wb_chunk),
    .wb_map     (wb_map),
    .chunk_dirty(chunk_dirty),
    .dirty_cnt  (dirty_cnt)
);

// File: tb/lazy_wb_tracker_bench.sv
// Bench: sweeps every chunk of an 8-chunk, 4-map configuration against a
// model kept in the bench.
module lazy_wb_tracker_bench;

    localparam int NC = 8;
    localparam int NM = 4;
    localparam int IW = 3;
    localparam int MW = 2;
    localparam int CW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic [IW-1:0]     st_chunk = '0;
    logic [MW-1:0]     st_map = '0;
    logic              ev_valid = 1'b0;
    logic              ev_ready;
    logic [IW-1:0]     ev_chunk = '0;
    logic              wb_valid;
    logic              wb_ready = 1'b0;
    logic [IW-1:0]     wb_chunk;
    logic [MW-1:0]     wb_map;
    logic [NC-1:0]     chunk_dirty;
    logic [NM*CW-1:0]  dirty_cnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit exp_dirty [NC];
    int exp_map   [NC];
    int exp_cnt   [NM];

    always #5 clk = ~clk;

    lazy_wb_tracker #(
        .NUM_CHUNKS(NC),
        .NUM_MAPS  (NM)
    ) u_lazy_wb_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .st_chunk   (st_chunk),
        .st_map     (st_map),
        .ev_valid   (ev_valid),
        .ev_ready   (ev_ready),
        .ev_chunk   (ev_chunk),
        .wb_valid   (wb_valid),
        .wb_ready   (wb_ready),
        .wb_chunk   (wb_chunk),
        .wb_map     (wb_map),
        .chunk_dirty(chunk_dirty),
        .dirty_cnt  (dirty_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every dirty bit and every count with the model.
    task automatic check_state(input string req);
        for (int c = 0; c < NC; c++) begin
            check({req, " dirty bit"}, int'(chunk_dirty[c]), int'(exp_dirty[c]));
        end
        for (int m = 0; m < NM; m++) begin
            check({req, " count"}, int'(dirty_cnt[m*CW +: CW]), exp_cnt[m]);
        end
    endtask

    task automatic do_store(input int c, input int m);
        string req;
        @(negedge clk);
        st_valid = 1'b1;
        st_chunk = IW'(c);
        st_map   = MW'(m);
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        if (exp_dirty[c]) begin
            req = "R3";
        end else begin
            req = "R2";
            exp_dirty[c] = 1'b1;
            exp_map[c]   = m;
            exp_cnt[m]++;
        end
        check_state(req);
        check("R8 no writeback from store", int'(wb_valid), 0);
    endtask

    task automatic do_evict(input int c, input int dly);
        @(negedge clk);
        check("R4 ev_ready idle", int'(ev_ready), 1);
        ev_valid = 1'b1;
        ev_chunk = IW'(c);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        if (exp_dirty[c]) begin
            check("R4 wb_valid", int'(wb_valid), 1);
            check("R4 wb_chunk", int'(wb_chunk), c);
            check("R4 wb_map owner", int'(wb_map), exp_map[c]);
            check("R4 ev_ready busy", int'(ev_ready), 0);
            for (int k = 0; k < dly; k++) begin
                @(posedge clk);
                @(negedge clk);
                check("R5 hold valid", int'(wb_valid), 1);
                check("R5 hold chunk", int'(wb_chunk), c);
                check("R5 hold map", int'(wb_map), exp_map[c]);
                check("R6 dirty until accept", int'(chunk_dirty[c]), 1);
            end
            wb_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wb_ready = 1'b0;
            exp_dirty[c] = 1'b0;
            exp_cnt[exp_map[c]]--;
            check("R6 valid drops", int'(wb_valid), 0);
            check_state("R6");
        end else begin
            check("R7 no writeback", int'(wb_valid), 0);
            check_state("R7");
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            exp_dirty[c] = 1'b0;
            exp_map[c]   = 0;
        end
        for (int m = 0; m < NM; m++) exp_cnt[m] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wb_valid", int'(wb_valid), 0);
        check("R1 ev_ready", int'(ev_ready), 1);
        check_state("R1");

        // First stores: every chunk dirtied by map (3c+1) mod 4.
        for (int c = 0; c < NC; c++) do_store(c, (3 * c + 1) % NM);
        // Repeat stores with other maps: nothing may change.
        for (int c = 0; c < NC; c++) do_store(c, (c + 2) % NM);

        // Evict even chunks with varied stalls; owners from first stores.
        for (int c = 0; c < NC; c += 2) do_evict(c, c % 3);
        // Evict them again while clean.
        for (int c = 0; c < NC; c += 2) do_evict(c, 1);

        // R10: writeback of chunk 1 (owner map 0) accepted while chunk 0
        // is first-written by map 0 in the same cycle.
        @(negedge clk);
        ev_valid = 1'b1;
        ev_chunk = IW'(1);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        check("R10 writeback pending", int'(wb_valid), 1);
        check("R10 owner", int'(wb_map), exp_map[1]);
        wb_ready = 1'b1;
        st_valid = 1'b1;
        st_chunk = IW'(0);
        st_map   = MW'(exp_map[1]);
        @(posedge clk);
        @(negedge clk);
        wb_ready = 1'b0;
        st_valid = 1'b0;
        exp_dirty[1] = 1'b0;
        exp_dirty[0] = 1'b1;
        exp_map[0]   = exp_map[1];
        check_state("R10");

        // Drain everything with stalls of 0..3.
        for (int c = NC - 1; c >= 0; c--) do_evict(c, (c + 1) % 4);
        for (int m = 0; m < NM; m++) check("R9 all counts zero", exp_cnt[m], 0);

        // Second pattern: map c mod 4, mixed order, eviction interleaved.
        for (int c = 0; c < NC; c++) do_store((5 * c) % NC, c % NM);
        for (int c = 0; c < NC; c += 3) do_evict(c, 2);
        for (int c = 0; c < NC; c++) do_store(c, 3);
        for (int c = 0; c < NC; c++) do_evict((3 * c + 1) % NC, c % 2);
        check_state("R9 final");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule